// File: doc/BRIEF.md
# Asynchronous NRZ Bit Retimer and Byte Packer

This block receives an asynchronous NRZ serial line from an external FSK demodulator running at a nominal 1200 baud. It recovers bit timing from the edges of the data itself. Each edge restarts a half-bit countdown, so the first sample after an edge lands near the middle of the bit. Between edges, a new sample is taken every full bit period. The sampled bits are shifted into bytes, with the earliest bit ending up in bit 0. Each finished byte is offered to a downstream receive FIFO with a single-cycle write strobe.

The block does not look for character boundaries, dot patterns or phasing sequences. It packs bits strictly in the order they arrive, and host software finds the alignment. Two qualifier pins gate the output:

- A mute pin, high when the radio has no signal.
- A carrier-detect pin, high while the demodulator sees valid data.

Bytes are written only while mute is low and detect is high. When that condition drops, the partial byte is discarded.

All three line inputs are asynchronous. Each passes through a resettable synchroniser chain before use. The bit period in system clocks is `CLK_HZ / BAUD`.

Top module: `nrz_retime_packer`

## Requirements
- R1: After reset, `wr_o` is low and `byte_o` is zero. No sample is taken, and no write happens, until the first transition of the synchronised data line after reset.
- R2: After each transition of the synchronised data line, the next sample is taken half a bit period (`BIT_CLKS/2` clocks) later. Two samples are never taken in adjacent clock cycles.
- R3: While no further transition occurs, samples follow one another every `BIT_CLKS` clocks. The period counter never exceeds `BIT_CLKS-1`.
- R4: The first sampled bit of each byte is placed in bit 0 of `byte_o`. Each later bit goes one position higher, and the eighth bit goes in bit 7.
- R5: Bytes are packed in arrival order, starting from the first sample taken while the qualifier is valid. No start-bit, preamble or pattern search shifts the byte boundary.
- R6: A byte is written only if `mute_i` was low and `det_i` was high, after synchronisation, when its eighth bit was sampled. Otherwise nothing is written.
- R7: While the qualifier is not valid, the partial byte and its bit index are cleared. When the qualifier becomes valid again, packing restarts at bit 0.
- R8: `wr_o` is high for exactly one clock per byte. `byte_o` changes only in a cycle where `wr_o` is high, and holds its value otherwise.
- R9: Bytes are recovered without error when the line rate differs from nominal by up to ±1.5%, provided the line has at least one transition in every ten bit periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Asynchronous NRZ serial data from the demodulator |
| mute_i | input | 1 | Asynchronous mute; high means no received signal |
| det_i | input | 1 | Asynchronous carrier detect; high means valid data |
| byte_o | output | BYTE_W (8) | Packed byte, bit 0 received first |
| wr_o | output | 1 | Single-cycle FIFO write strobe |

## Verification
The embedded assertions check, on every cycle:

- that the period counter stays in range;
- that samples are never adjacent;
- that the bit index stays inside a byte and returns to zero whenever the qualifier is invalid;
- that every write follows a valid qualifier;
- that the strobe lasts a single cycle and the byte changes only when the strobe is high.

Only the bench's scenarios can show which bit value lands in which byte position. They also show that:

- the centre sampling survives ten-bit runs at ±1.5% rate error;
- a dropped qualifier discards exactly the partial byte;
- nothing is written before the first transition after reset.

// File: rtl/nrz_pkg.sv
package nrz_pkg;

   localparam int unsigned NOMINAL_BAUD = 1200;

   // One recovered bit, offered for a single clock.
   typedef struct packed {
      logic valid;
      logic value;
   } sample_t;

endpackage

// File: rtl/nrz_sync.sv
// Resettable multi-stage synchroniser with a matching "filled" flag.
module nrz_sync #(
   parameter int unsigned   STAGES  = 2,
   parameter int unsigned   W       = 1,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic         vld_o
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("nrz_sync: STAGES must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("nrz_sync: W must be at least 1");
      end
   endgenerate

   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] stage_q;
         logic         fill_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               stage_q <= RST_VAL;
               fill_q  <= 1'b0;
            end else begin
               stage_q <= d_i;
               fill_q  <= 1'b1;
            end
         end

         assign q_o   = stage_q;
         assign vld_o = fill_q;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] chain_q;
         logic [STAGES-1:0]        fill_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               chain_q <= {STAGES{RST_VAL}};
               fill_q  <= '0;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], d_i};
               fill_q  <= {fill_q[STAGES-2:0], 1'b1};
            end
         end

         assign q_o   = chain_q[STAGES-1];
         assign vld_o = fill_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/nrz_bit_timer.sv
// Edge-resynchronised bit-centre sampler.
module nrz_bit_timer
   import nrz_pkg::*;
#(
   parameter int unsigned BIT_CLKS = 4096
) (
   input  logic    clk_i,
   input  logic    rst_ni,
   input  logic    line_i,
   input  logic    line_vld_i,
   output sample_t smp_o
);

   localparam int unsigned HALF_CLKS = BIT_CLKS / 2;
   localparam int unsigned CNT_W     = $clog2(BIT_CLKS);

   typedef logic [CNT_W-1:0] cnt_t;

   localparam cnt_t FULL_LOAD = cnt_t'(BIT_CLKS - 1);
   localparam cnt_t HALF_LOAD = cnt_t'(HALF_CLKS - 1);

   generate
      if (BIT_CLKS < 8) begin : g_bad_period
         $error("nrz_bit_timer: BIT_CLKS must be at least 8");
      end
   endgenerate

   logic    prev_q;
   logic    prev_vld_q;
   logic    armed_q;
   cnt_t    cnt_q;
   logic    edge_w;
   logic    tick_w;
   sample_t smp_q;

   // A transition counts only once both samples compared are real line values.
   assign edge_w = line_vld_i & prev_vld_q & (line_i ^ prev_q);
   assign tick_w = armed_q & ~edge_w & (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q     <= 1'b0;
         prev_vld_q <= 1'b0;
         armed_q    <= 1'b0;
         cnt_q      <= '0;
         smp_q      <= '0;
      end else begin
         prev_q     <= line_i;
         prev_vld_q <= line_vld_i;
         if (edge_w) begin
            armed_q <= 1'b1;
            cnt_q   <= HALF_LOAD;
         end else if (armed_q) begin
            cnt_q <= tick_w ? FULL_LOAD : cnt_q - 1'b1;
         end
         smp_q.valid <= tick_w;
         smp_q.value <= line_i;
      end
   end

   assign smp_o = smp_q;

   assert_cnt_range_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= FULL_LOAD);

   assert_no_adjacent_samples_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_q.valid |=> !smp_q.valid);

   assert_idle_until_edge_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !armed_q |-> (cnt_q == '0) && !tick_w);

endmodule

// File: rtl/nrz_byte_packer.sv
// Shifts samples into bytes, first bit at the least significant end.
module nrz_byte_packer
   import nrz_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  sample_t           smp_i,
   input  logic              qual_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              wr_o
);

   localparam int unsigned IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

   typedef logic [IDX_W-1:0] idx_t;

   localparam idx_t LAST_IDX = idx_t'(BYTE_W - 1);

   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("nrz_byte_packer: BYTE_W must be at least 2");
      end
   endgenerate

   logic [BYTE_W-1:0] shift_q;
   logic [BYTE_W-1:0] byte_q;
   logic [BYTE_W-1:0] shift_nxt;
   idx_t              idx_q;
   logic              wr_q;

   assign shift_nxt = {smp_i.value, shift_q[BYTE_W-1:1]};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shift_q <= '0;
         byte_q  <= '0;
         idx_q   <= '0;
         wr_q    <= 1'b0;
      end else begin
         wr_q <= 1'b0;
         if (!qual_i) begin
            shift_q <= '0;
            idx_q   <= '0;
         end else if (smp_i.valid) begin
            shift_q <= shift_nxt;
            if (idx_q == LAST_IDX) begin
               idx_q  <= '0;
               byte_q <= shift_nxt;
               wr_q   <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign byte_o = byte_q;
   assign wr_o   = wr_q;

   assert_write_needs_qual_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_q |-> $past(qual_i) && $past(smp_i.valid));

   assert_clear_on_unqual_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !qual_i |=> (idx_q == '0) && !wr_q);

   assert_idx_in_byte_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx_q <= LAST_IDX);

endmodule

// File: rtl/nrz_retime_packer.sv
module nrz_retime_packer
   import nrz_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 4_915_200,
   parameter int unsigned BAUD        = NOMINAL_BAUD,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rxd_i,
   input  logic              mute_i,
   input  logic              det_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              wr_o
);

   localparam int unsigned BIT_CLKS = CLK_HZ / BAUD;

   generate
      if (BAUD == 0) begin : g_bad_baud
         $error("nrz_retime_packer: BAUD must be non-zero");
      end
   endgenerate

   logic       line_s;
   logic       line_vld;
   logic [1:0] ctl_s;
   logic       ctl_vld;
   logic       qual;
   sample_t    smp;

   nrz_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (1),
      .RST_VAL (1'b0)
   ) i_line_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (rxd_i),
      .q_o    (line_s),
      .vld_o  (line_vld)
   );

   // Reset value {mute, detect} = {1, 0}: qualifier starts invalid.
   nrz_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (2),
      .RST_VAL (2'b10)
   ) i_ctl_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({mute_i, det_i}),
      .q_o    (ctl_s),
      .vld_o  (ctl_vld)
   );

   assign qual = ctl_vld & ~ctl_s[1] & ctl_s[0];

   nrz_bit_timer #(
      .BIT_CLKS (BIT_CLKS)
   ) i_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .line_i     (line_s),
      .line_vld_i (line_vld),
      .smp_o      (smp)
   );

   nrz_byte_packer #(
      .BYTE_W (BYTE_W)
   ) i_packer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp),
      .qual_i (qual),
      .byte_o (byte_o),
      .wr_o   (wr_o)
   );

   assert_single_strobe_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_o |=> !wr_o);

   assert_byte_held_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_o |-> $stable(byte_o));

endmodule

// File: tb/test_nrz_retime_packer.sv
`timescale 1ns/1ps
module test_nrz_retime_packer;

   localparam int  CLK_NS   = 10;
   localparam int  CLK_HZ   = 38_400;  // 32 clocks per bit at 1200 baud
   localparam real BIT_NS   = 320.0;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       rxd;
   logic       mute;
   logic       det;
   logic [7:0] byte_w;
   logic       wr;

   logic [7:0] exp_q[$];
   logic [7:0] exp_b;
   int         total = 0;
   int         bad = 0;
   int         writes = 0;
   string      cur_req = "R5";

   always #(CLK_NS/2) clk = ~clk;

   nrz_retime_packer #(
      .CLK_HZ (CLK_HZ)
   ) i_nrz_retime_packer (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .rxd_i  (rxd),
      .mute_i (mute),
      .det_i  (det),
      .byte_o (byte_w),
      .wr_o   (wr)
   );

   // Monitor: pop expected bytes as the design writes them.
   always @(negedge clk) begin
      if (rst_n === 1'b1 && wr === 1'b1) begin
         writes++;
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R6 unexpected write: actual=%02h expected=none", byte_w);
         end else begin
            exp_b = exp_q.pop_front();
            if (byte_w !== exp_b) begin
               bad++;
               $display("FAIL %s byte: actual=%02h expected=%02h", cur_req, byte_w, exp_b);
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_bits(input logic [7:0] b, input int n, input real bit_ns);
      for (int i = 0; i < n; i++) begin
         rxd = b[i];
         #(bit_ns);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input real bit_ns, input bit expect_it);
      if (expect_it) exp_q.push_back(b);
      send_bits(b, 8, bit_ns);
   endtask

   // Reset with the line idling opposite to the first data bit.
   task automatic start(input logic idle, input logic m, input logic d);
      rst_n = 1'b0;
      rxd   = idle;
      mute  = m;
      det   = d;
      exp_q.delete();
      repeat (4) @(negedge clk);
      check(wr === 1'b0 && byte_w === 8'h00, "R1 reset state", int'(byte_w), 0);
      rst_n = 1'b1;
      writes = 0;
      #(5.0 * BIT_NS);
      // R1: no sample or write before the first line transition
      check(writes == 0, "R1 no write before first edge", writes, 0);
   endtask

   task automatic finish_scn(input string req, input real bit_ns);
      mute = 1'b1;
      #(4.0 * bit_ns);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   initial begin
      #(CLK_NS * 150000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // Scenario A: nominal rate, mixed patterns, LSB first (R2/R3/R4/R5/R8)
      cur_req = "R2/R3/R4/R5";
      start(1'b0, 1'b0, 1'b1);
      send_byte(8'h55, BIT_NS, 1'b1);
      send_byte(8'hA3, BIT_NS, 1'b1);
      send_byte(8'h00, BIT_NS, 1'b1);
      send_byte(8'h3C, BIT_NS, 1'b1);   // ten-bit run of zeros across the boundary
      send_byte(8'h96, BIT_NS, 1'b1);
      send_byte(8'hF0, BIT_NS, 1'b1);
      finish_scn("R5 all nominal bytes written in order", BIT_NS);

      // Scenario B: line 1.5% fast with ten-bit runs (R9)
      cur_req = "R9 fast";
      start(1'b1, 1'b0, 1'b1);
      send_byte(8'h00, BIT_NS * 0.985, 1'b1);
      send_byte(8'h3C, BIT_NS * 0.985, 1'b1);
      send_byte(8'hFF, BIT_NS * 0.985, 1'b1);
      send_byte(8'h03, BIT_NS * 0.985, 1'b1);
      send_byte(8'h6E, BIT_NS * 0.985, 1'b1);
      finish_scn("R9 fast bytes complete", BIT_NS * 0.985);

      // Scenario C: line 1.5% slow with ten-bit runs (R9)
      cur_req = "R9 slow";
      start(1'b1, 1'b0, 1'b1);
      send_byte(8'h00, BIT_NS * 1.015, 1'b1);
      send_byte(8'h3C, BIT_NS * 1.015, 1'b1);
      send_byte(8'hFF, BIT_NS * 1.015, 1'b1);
      send_byte(8'h03, BIT_NS * 1.015, 1'b1);
      send_byte(8'hB1, BIT_NS * 1.015, 1'b1);
      finish_scn("R9 slow bytes complete", BIT_NS * 1.015);

      // Scenario D: mute mid-byte discards the partial byte (R6/R7)
      cur_req = "R7 mute";
      start(1'b0, 1'b0, 1'b1);
      send_byte(8'h5B, BIT_NS, 1'b1);
      send_bits(8'h05, 3, BIT_NS);      // partial byte, later dropped
      mute = 1'b1;
      send_bits(8'h2D, 6, BIT_NS);      // muted bits, never written
      mute = 1'b0;
      send_byte(8'hC7, BIT_NS, 1'b1);   // packing restarts at bit 0
      send_byte(8'h21, BIT_NS, 1'b1);
      finish_scn("R7 mute partial discarded", BIT_NS);

      // Scenario E: detect low mid-byte discards the partial byte (R6/R7)
      cur_req = "R7 detect";
      start(1'b1, 1'b0, 1'b1);
      send_byte(8'h4A, BIT_NS, 1'b1);
      send_bits(8'h1F, 5, BIT_NS);
      det = 1'b0;
      send_bits(8'h0A, 4, BIT_NS);
      det = 1'b1;
      send_byte(8'h93, BIT_NS, 1'b1);
      finish_scn("R7 detect partial discarded", BIT_NS);

      // Scenario F: detect never high, nothing written (R6)
      cur_req = "R6 gated";
      start(1'b0, 1'b0, 1'b0);
      send_byte(8'h55, BIT_NS, 1'b0);
      send_byte(8'hE2, BIT_NS, 1'b0);
      send_byte(8'h0F, BIT_NS, 1'b0);
      check(writes == 0, "R6 detect low blocks writes", writes, 0);

      // Scenario G: mute high throughout, nothing written (R6)
      start(1'b0, 1'b1, 1'b1);
      send_byte(8'hAD, BIT_NS, 1'b0);
      send_byte(8'h77, BIT_NS, 1'b0);
      check(writes == 0, "R6 mute high blocks writes", writes, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule